// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor with Component Selector

This block predicts whether a conditional branch will be taken by running two direction predictors side by side and letting a third table choose between them. The global component keeps one saturating 2-bit counter per pattern of recent branch outcomes. That pattern is a shift register holding the last `GHIST_W` resolved branches from any address. The local component works in two levels. A table of per-address outcome histories is selected by instruction-address bits, and the history it returns picks a 3-bit saturating counter. The selector table is indexed by the same global pattern as the global component. It holds 2-bit counters that learn which of the two components to trust in that context.

A fetch stage presents an instruction address on the predict pins. In the same cycle it gets back the final direction and both component directions. This lookup is a pure combinational query and changes no state. When a branch resolves, the execute stage offers its address and actual outcome on the update stream, which is a valid/ready pair. The block then re-reads all three tables with the histories as they stand at that moment and trains every counter. Only after that does it shift the outcome into the global pattern and into the selected local history entry. Histories are never advanced speculatively.

Back-pressure on the update stream is simple. `upd_ready` is low while reset is asserted and during the first clock edge after release. It then stays high, and one update is consumed on every edge where `upd_valid` and `upd_ready` are both high. A producer must hold its payload stable until that edge. With `upd_valid` low, every table and history keeps its contents.

Top module: `tournament_bp`

## Requirements
- R1: After reset every global counter holds 1, every local counter holds 3, every selector counter holds 1 (weakly trust local), and all histories are zero. Every address is therefore predicted not-taken by both components and by the final output.
- R2: The global pattern is a `GHIST_W`-bit register. On each accepted update it shifts left and the outcome (1 = taken) enters bit 0, so bit i holds the outcome of the branch resolved i+1 updates ago.
- R3: Global counters are 2 bits wide and indexed by the global pattern. The global direction is the counter's top bit. On update the counter adds one if the branch was taken and subtracts one if not, saturating at 0 and 3.
- R4: The local history entry is selected by address bits `[LHT_IDX_W+1:2]`. On update that entry shifts left with the outcome entering bit 0.
- R5: Local counters are 3 bits wide and indexed by the selected local history. The local direction is the counter's top bit. They count toward the outcome and saturate at 0 and 7.
- R6: Selector counters are indexed by the global pattern. A top bit of 1 selects the global direction as the final output; a top bit of 0 selects the local direction.
- R7: A selector counter increments (saturating at 3) only when the global component was right and the local was wrong. It decrements (saturating at 0) only in the opposite case. It is unchanged when both were right or both were wrong.
- R8: An update computes correctness and trains all counters using the histories held before that update. Both histories shift at the same clock edge.
- R9: `upd_ready` is 0 during reset and 1 from the second clock edge after reset release onward. An update is consumed only when `upd_valid` and `upd_ready` are both 1. An edge without one leaves every prediction unchanged.
- R10: The predict outputs are a combinational function of `pred_pc` and the stored state. Any number of lookups leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Final predicted direction, 1 = taken |
| pred_global | output | 1 | Direction given by the global component |
| pred_local | output | 1 | Direction given by the local component |
| upd_valid | input | 1 | Update stream: a resolved branch is offered |
| upd_ready | output | 1 | Update stream: block accepts an update this edge |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench shrinks every table to a handful of entries. It then compares all three predict outputs, at every local-history slot, against an arithmetic model after each of several thousand updates. This catches a selector that moves when both components agree on correctness; such a design would drift toward global on easy branches and flip final directions the model keeps. Long runs of identical outcomes push counters into saturation, where a counter that wraps would suddenly predict the opposite direction. Alternating and loop-shaped outcome streams expose histories that shift before training or shift the wrong end: the design would then train a counter other than the one the model trains. Idle edges with a taken outcome on the pins, and repeated lookups, catch a design that trains without a handshake or whose lookup disturbs state.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Bundle of the three directions produced by one lookup.
  typedef struct packed {
    logic final_dir;
    logic glob;
    logic loc;
  } tp_pred_t;

  // Selector movement derived from component correctness.
  typedef enum logic [1:0] {
    SEL_HOLD   = 2'b00,
    SEL_GLOBAL = 2'b01,
    SEL_LOCAL  = 2'b10
  } sel_move_e;

  // One saturating step; counters up to 8 bits wide are carried in a byte.
  function automatic logic [7:0] sat_move(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic       up,
                                          input logic       en);
    logic [7:0] r;
    r = v;
    if (en) begin
      if (up) begin
        if (v != top) r = v + 8'd1;
      end else begin
        if (v != 8'd0) r = v - 8'd1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2,
  parameter int INIT  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] qa_idx,
  output logic [CTR_W-1:0] qa_val,
  input  logic [IDX_W-1:0] qb_idx,
  output logic [CTR_W-1:0] qb_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CTR_W-1:0] wr_val
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int MAXV  = (1 << CTR_W) - 1;

  logic [CTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_W'(INIT);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_val;
    end
  end

  assign qa_val = mem[qa_idx];
  assign qb_val = mem[qb_idx];

  // R3 R5 R7: a write moves a counter by at most one step.
  p_ctr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_val == mem[wr_idx]) ||
              (wr_val == mem[wr_idx] + CTR_W'(1)) ||
              (wr_val == mem[wr_idx] - CTR_W'(1)));

  // R5: no wrap from the top to zero.
  p_ctr_top_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mem[wr_idx] == CTR_W'(MAXV)) |-> (wr_val != '0));

  // R5: no wrap from zero to the top.
  p_ctr_bot_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mem[wr_idx] == '0) |-> (wr_val != CTR_W'(MAXV)));

endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  qa_idx,
  output logic [HIST_W-1:0] qa_hist,
  input  logic [IDX_W-1:0]  qb_idx,
  output logic [HIST_W-1:0] qb_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [HIST_W-1:0] wr_hist
);

  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_hist;
    end
  end

  assign qa_hist = mem[qa_idx];
  assign qb_hist = mem[qb_idx];

  // R4: a write keeps the older outcomes, moved up by one place.
  p_lhist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_hist[HIST_W-1:1] == mem[wr_idx][HIST_W-2:0]));

endmodule

// File: rtl/tournament_bp.sv
module tournament_bp #(
  parameter int PC_W      = 32,
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int GCTR_W    = 2,
  parameter int LCTR_W    = 3,
  parameter int SCTR_W    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_global,
  output logic            pred_local,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  import tp_pkg::*;

  localparam int GMAX  = (1 << GCTR_W) - 1;
  localparam int LMAX  = (1 << LCTR_W) - 1;
  localparam int SMAX  = (1 << SCTR_W) - 1;
  localparam int GINIT = (1 << (GCTR_W - 1)) - 1;
  localparam int LINIT = (1 << (LCTR_W - 1)) - 1;
  localparam int SINIT = (1 << (SCTR_W - 1)) - 1;
  localparam int PC_LO = 2;

  logic                 ready_q;
  logic                 fire;
  logic [GHIST_W-1:0]   ghist;

  // Lookup side
  logic [LHT_IDX_W-1:0] p_lidx;
  logic [LHIST_W-1:0]   p_lhist;
  logic [GCTR_W-1:0]    p_gcnt;
  logic [LCTR_W-1:0]    p_lcnt;
  logic [SCTR_W-1:0]    p_scnt;
  tp_pred_t             p_out;

  // Training side
  logic [LHT_IDX_W-1:0] u_lidx;
  logic [LHIST_W-1:0]   u_lhist;
  logic [GCTR_W-1:0]    u_gcnt;
  logic [LCTR_W-1:0]    u_lcnt;
  logic [SCTR_W-1:0]    u_scnt;
  logic                 u_gdir, u_ldir, g_ok, l_ok;
  sel_move_e            s_move;
  logic [GCTR_W-1:0]    g_new;
  logic [LCTR_W-1:0]    l_new;
  logic [SCTR_W-1:0]    s_new;
  logic [LHIST_W-1:0]   lh_new;

  // Update stream handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign upd_ready = ready_q;
  assign fire      = upd_valid & ready_q;

  // Global outcome pattern, newest outcome in bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ghist <= '0;
    else if (fire) ghist <= {ghist[GHIST_W-2:0], upd_taken};
  end

  assign p_lidx = pred_pc[PC_LO +: LHT_IDX_W];
  assign u_lidx = upd_pc[PC_LO +: LHT_IDX_W];

  tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) lht_i (
    .clk(clk), .rst_n(rst_n),
    .qa_idx(p_lidx), .qa_hist(p_lhist),
    .qb_idx(u_lidx), .qb_hist(u_lhist),
    .wr_en(fire), .wr_idx(u_lidx), .wr_hist(lh_new)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .INIT(LINIT)) lctr_i (
    .clk(clk), .rst_n(rst_n),
    .qa_idx(p_lhist), .qa_val(p_lcnt),
    .qb_idx(u_lhist), .qb_val(u_lcnt),
    .wr_en(fire), .wr_idx(u_lhist), .wr_val(l_new)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .INIT(GINIT)) gctr_i (
    .clk(clk), .rst_n(rst_n),
    .qa_idx(ghist), .qa_val(p_gcnt),
    .qb_idx(ghist), .qb_val(u_gcnt),
    .wr_en(fire), .wr_idx(ghist), .wr_val(g_new)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(SCTR_W), .INIT(SINIT)) sctr_i (
    .clk(clk), .rst_n(rst_n),
    .qa_idx(ghist), .qa_val(p_scnt),
    .qb_idx(ghist), .qb_val(u_scnt),
    .wr_en(fire), .wr_idx(ghist), .wr_val(s_new)
  );

  // Lookup result
  always_comb begin
    p_out.glob      = p_gcnt[GCTR_W-1];
    p_out.loc       = p_lcnt[LCTR_W-1];
    p_out.final_dir = p_scnt[SCTR_W-1] ? p_out.glob : p_out.loc;
  end
  assign pred_taken  = p_out.final_dir;
  assign pred_global = p_out.glob;
  assign pred_local  = p_out.loc;

  // Training: component correctness against pre-update state
  assign u_gdir = u_gcnt[GCTR_W-1];
  assign u_ldir = u_lcnt[LCTR_W-1];
  assign g_ok   = (u_gdir == upd_taken);
  assign l_ok   = (u_ldir == upd_taken);

  always_comb begin
    unique case ({g_ok, l_ok})
      2'b10:   s_move = SEL_GLOBAL;
      2'b01:   s_move = SEL_LOCAL;
      default: s_move = SEL_HOLD;
    endcase
  end

  assign g_new  = GCTR_W'(sat_move(8'(u_gcnt), 8'(GMAX), upd_taken, 1'b1));
  assign l_new  = LCTR_W'(sat_move(8'(u_lcnt), 8'(LMAX), upd_taken, 1'b1));
  assign s_new  = SCTR_W'(sat_move(8'(u_scnt), 8'(SMAX), s_move == SEL_GLOBAL,
                                   s_move != SEL_HOLD));
  assign lh_new = {u_lhist[LHIST_W-2:0], upd_taken};

  // R9: the handshake is open after the first edge out of reset.
  p_ready_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> upd_ready);

  // R9: without a handshake the global pattern holds.
  p_ghist_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(ghist));

  // R2: the consumed outcome becomes the newest pattern bit.
  p_ghist_newest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ghist[0] == $past(upd_taken)));

  // R7: a selector change implies exactly one component was right.
  p_sel_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (s_new != u_scnt)) |-> (g_ok != l_ok));

  // R6: when the components agree the final output follows them.
  p_agree_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_global == pred_local) |-> (pred_taken == pred_global));

endmodule

// File: tb/tournament_bp_tb.sv
module tournament_bp_tb_top;

  localparam int PC_W = 8;
  localparam int GH_W = 3;
  localparam int LI_W = 2;
  localparam int LH_W = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] pred_pc = '0;
  logic            pred_taken, pred_global, pred_local;
  logic            upd_valid = 1'b0;
  logic            upd_ready;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model state
  logic [1:0]      gm [1 << GH_W];
  logic [2:0]      lm [1 << LH_W];
  logic [1:0]      cm [1 << GH_W];
  logic [LH_W-1:0] lh [1 << LI_W];
  logic [GH_W-1:0] gh;
  logic [15:0]     lfsr = 16'hACE1;

  always #10 clk = ~clk;

  tournament_bp #(
    .PC_W(PC_W), .GHIST_W(GH_W), .LHT_IDX_W(LI_W), .LHIST_W(LH_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_global(pred_global), .pred_local(pred_local),
    .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < (1 << GH_W); i++) begin gm[i] = 2'd1; cm[i] = 2'd1; end
    for (int i = 0; i < (1 << LH_W); i++) lm[i] = 3'd3;
    for (int i = 0; i < (1 << LI_W); i++) lh[i] = '0;
    gh = '0;
  endtask

  // Compare all outputs at every local-history slot against the model
  task automatic check_all(input string phase);
    for (int s = 0; s < (1 << LI_W); s++) begin
      logic [LH_W-1:0] h;
      logic g, l, f;
      pred_pc = PC_W'({lfsr[7:4], 4'b0} | (s << 2));
      h = lh[s];
      g = gm[gh][1];
      l = lm[h][2];
      f = cm[gh][1] ? g : l;
      #1;
      chk({phase, " R2 R3 global"}, pred_global, g);
      chk({phase, " R4 R5 local"}, pred_local, l);
      chk({phase, " R6 R7 R8 final"}, pred_taken, f);
    end
  endtask

  task automatic do_update(input logic [PC_W-1:0] pc, input logic t);
    int li;
    logic [LH_W-1:0] h;
    logic gok, lok;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
    @(negedge clk);
    upd_valid = 1'b0;
    li  = int'(pc[2 +: LI_W]);
    h   = lh[li];
    gok = (gm[gh][1] == t);
    lok = (lm[h][2] == t);
    if (t) begin
      if (gm[gh] != 2'd3) gm[gh] = gm[gh] + 2'd1;
      if (lm[h] != 3'd7)  lm[h]  = lm[h] + 3'd1;
    end else begin
      if (gm[gh] != 2'd0) gm[gh] = gm[gh] - 2'd1;
      if (lm[h] != 3'd0)  lm[h]  = lm[h] - 3'd1;
    end
    if (gok && !lok && cm[gh] != 2'd3) cm[gh] = cm[gh] + 2'd1;
    if (lok && !gok && cm[gh] != 2'd0) cm[gh] = cm[gh] - 2'd1;
    lh[li] = {h[LH_W-2:0], t};
    gh     = {gh[GH_W-2:0], t};
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R9: handshake closed during reset
    chk("R9 ready in reset", upd_ready, 1'b0);
    // R1: reset contents
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 ready after reset", upd_ready, 1'b1);
    check_all("R1 after release");

    // Saturation: long taken then long not-taken runs on each slot
    for (int s = 0; s < (1 << LI_W); s++) begin
      for (int k = 0; k < 12; k++) begin do_update(PC_W'(s << 2), 1'b1); check_all("sat-up"); end
      for (int k = 0; k < 12; k++) begin do_update(PC_W'(s << 2), 1'b0); check_all("sat-down"); end
    end

    // Alternating outcomes
    for (int k = 0; k < 200; k++) begin
      do_update(PC_W'((k % 4) << 2), k[0]);
      check_all("alternate");
    end

    // Loop-shaped: three taken then one not-taken on one address
    for (int k = 0; k < 200; k++) begin
      do_update(PC_W'(8'h24), (k % 4) != 3);
      check_all("loop");
    end

    // R9: idle edges with a taken outcome on the pins change nothing
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = 8'h0C; upd_taken = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R9 idle");

    // R10: repeated lookups leave state alone
    check_all("R10 lookup 1");
    check_all("R10 lookup 2");

    // Pseudo-random mixed sweep, aliasing upper address bits
    for (int k = 0; k < 3000; k++) begin
      lfsr = step(lfsr);
      do_update(lfsr[7:0], lfsr[9] | (lfsr[11] & lfsr[3]));
      check_all("mixed");
    end

    check_all("R10 final");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule